// File: doc/BRIEF.md
# 1-Wire Time-Slot Bus Master

This block is the timing core of a 1-Wire bus master. It takes one slot command at a time over a valid/ready handshake and plays out that slot on an open-drain line. The slot can be a bus reset, a write of 0, a write of 1 or a read. All timing is counted in ticks of a 1 MHz enable, so one count is one microsecond. For the first part of every slot the block pulls the line low. After it lets go, it records the tick count at which the line was last seen rising. It compares that count with a fixed threshold to decide whether a device answered the reset or which bit a device returned.

A sequencer above the block splits bytes into slots, least-significant bit first, and issues them back to back. A full command sequence is at most twenty bytes, or 160 slots. Each read result is also shifted into a byte register from the top, so after eight reads the first bit received sits in bit 0. The line level is synchronised inside the block before it is used.

Top module: `ow_slot_engine`

## Requirements
- R1: While reset is held and just after it, `drive_low`, `presence`, `rd_bit`, `rd_valid` and `slot_done` are 0, `rd_byte` is 0 and `cmd_ready` is 1.
- R2: A command is taken on a clock edge where `cmd_valid` and `cmd_ready` are both 1. `cmd_ready` then stays 0 for the whole slot. A reset slot lasts exactly 1000 ticks and every other slot lasts exactly 100 ticks.
- R3: `cmd_kind` encodes 0 = reset, 1 = write-0, 2 = write-1 and 3 = read. The line is held low from acceptance for 500 ticks (reset), 60 ticks (write-0), 6 ticks (write-1) or 2 ticks (read). `drive_low` is never 1 outside a slot.
- R4: At the end of a reset slot, `presence` is set to 1 when the last rising edge after release was captured at a count above 550 and before the slot ended. Otherwise it is set to 0. No other slot changes it.
- R5: At the end of a read slot, `rd_bit` becomes 1 when the last rising edge after release was captured at a count below 10, and 0 otherwise. `rd_valid` pulses for one cycle together with `slot_done`.
- R6: If no rising edge occurs after release, the captured count is the full slot length. A reset slot then reports no presence and a read slot returns 0.
- R7: Each read bit enters `rd_byte` at bit 7 and shifts toward bit 0. After eight reads, `rd_byte` holds the first bit received in bit 0 (least-significant bit first).
- R8: `slot_done` is a single-cycle pulse, given once per slot, after the slot's last tick.
- R9: A command held valid while a slot runs is not taken, and its kind does not affect the running slot. It is accepted only after the full slot period and then runs with its own timing.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| tick_1us | input | 1 | One-cycle enable at 1 MHz; timing unit |
| cmd_valid | input | 1 | Slot command offered |
| cmd_ready | output | 1 | Engine idle; command accepted when valid |
| cmd_kind | input | 2 | Slot kind: 0 reset, 1 write-0, 2 write-1, 3 read |
| line_in | input | 1 | Sensed bus level (asynchronous) |
| drive_low | output | 1 | Enable of the open-drain pull-down |
| presence | output | 1 | Device answered the last reset slot |
| rd_bit | output | 1 | Bit recovered by the last read slot |
| rd_byte | output | 8 | Read bits assembled least-significant first |
| rd_valid | output | 1 | One-cycle strobe: rd_bit/rd_byte updated |
| slot_done | output | 1 | One-cycle strobe at the end of each slot |

## Verification
Assertions check several rules on every cycle. The pull-down is active only inside a slot, and the slot counter stays below the latched length. The captured rise count never exceeds that length. The done and read strobes are single-cycle and aligned with each other, and the handshake drops ready after an acceptance. Presence changes only when a reset slot ends. Only the directed scenarios can show the actual low and slot durations in ticks, the threshold decisions for early, late and missing rising edges, the least-significant-first byte assembly, and that a command waiting during a slot keeps its own timing.

// File: rtl/ow_slot_pkg.sv
package ow_slot_pkg;
  typedef enum logic [1:0] {
    SLOT_RESET = 2'd0,
    SLOT_WR0   = 2'd1,
    SLOT_WR1   = 2'd2,
    SLOT_READ  = 2'd3
  } slot_kind_e;
endpackage

// File: rtl/ow_line_sync.sv
module ow_line_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic line_in,
  output logic line_s,
  output logic rise
);
  logic [STAGES-1:0] sh;
  logic              prev;

  for (genvar g = 0; g < STAGES; g++) begin : g_stage
    if (g == 0) begin : g_first
      always_ff @(posedge clk) begin
        if (rst) sh[g] <= 1'b1;
        else     sh[g] <= line_in;
      end
    end else begin : g_next
      always_ff @(posedge clk) begin
        if (rst) sh[g] <= 1'b1;
        else     sh[g] <= sh[g-1];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) prev <= 1'b1;
    else     prev <= sh[STAGES-1];
  end

  assign line_s = sh[STAGES-1];
  assign rise   = sh[STAGES-1] & ~prev;
endmodule

// File: rtl/ow_slot_timer.sv
module ow_slot_timer #(
  parameter int CNT_W = 10
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             tick,
  input  logic             start,
  input  logic [CNT_W-1:0] low_len,
  input  logic [CNT_W-1:0] slot_len,
  output logic [CNT_W-1:0] cnt,
  output logic             busy,
  output logic             drive_low,
  output logic             end_pulse
);
  logic [CNT_W-1:0] low_q, len_q;
  logic [CNT_W-1:0] cnt_nxt;

  assign cnt_nxt = cnt + 1'b1;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt       <= '0;
      busy      <= 1'b0;
      drive_low <= 1'b0;
      end_pulse <= 1'b0;
      low_q     <= '0;
      len_q     <= '0;
    end else begin
      end_pulse <= 1'b0;
      if (start) begin
        cnt       <= '0;
        busy      <= 1'b1;
        drive_low <= (low_len != '0);
        low_q     <= low_len;
        len_q     <= slot_len;
      end else if (busy && tick) begin
        cnt       <= cnt_nxt;
        drive_low <= (cnt_nxt < low_q);
        if (cnt_nxt == len_q) begin
          busy      <= 1'b0;
          drive_low <= 1'b0;
          end_pulse <= 1'b1;
        end
      end
    end
  end

  assert_drive_in_slot_R3: assert property (@(posedge clk) disable iff (rst)
    drive_low |-> busy);
  assert_cnt_below_len_R2: assert property (@(posedge clk) disable iff (rst)
    busy |-> (cnt < len_q));
  assert_end_frees_R2: assert property (@(posedge clk) disable iff (rst)
    end_pulse |-> !busy);
endmodule

// File: rtl/ow_rise_capture.sv
module ow_rise_capture #(
  parameter int CNT_W = 10
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             start,
  input  logic [CNT_W-1:0] slot_len,
  input  logic             busy,
  input  logic             drive_low,
  input  logic [CNT_W-1:0] cnt,
  input  logic             rise,
  output logic [CNT_W-1:0] cap
);
  logic [CNT_W-1:0] len_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      cap   <= '0;
      len_q <= '0;
    end else if (start) begin
      cap   <= slot_len;
      len_q <= slot_len;
    end else if (busy && !drive_low && rise) begin
      cap <= cnt;
    end
  end

  assert_cap_bounded_R6: assert property (@(posedge clk) disable iff (rst)
    cap <= len_q);
endmodule

// File: rtl/ow_slot_engine.sv
module ow_slot_engine #(
  parameter int RESET_LEN   = 1000,
  parameter int RESET_LOW   = 500,
  parameter int PRES_BAR    = 550,
  parameter int BIT_LEN     = 100,
  parameter int WR0_LOW     = 60,
  parameter int WR1_LOW     = 6,
  parameter int RD_LOW      = 2,
  parameter int RD_BAR      = 10,
  parameter int SYNC_STAGES = 2,
  parameter int BYTE_W      = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              tick_1us,
  input  logic              cmd_valid,
  output logic              cmd_ready,
  input  logic [1:0]        cmd_kind,
  input  logic              line_in,
  output logic              drive_low,
  output logic              presence,
  output logic              rd_bit,
  output logic [BYTE_W-1:0] rd_byte,
  output logic              rd_valid,
  output logic              slot_done
);
  import ow_slot_pkg::*;

  localparam int CNT_W = $clog2(RESET_LEN + 1);
  localparam logic [CNT_W-1:0] L_RESET = CNT_W'(RESET_LEN);
  localparam logic [CNT_W-1:0] L_BIT   = CNT_W'(BIT_LEN);
  localparam logic [CNT_W-1:0] B_PRES  = CNT_W'(PRES_BAR);
  localparam logic [CNT_W-1:0] B_READ  = CNT_W'(RD_BAR);

  slot_kind_e       kind_q;
  logic             busy, end_pulse, start;
  logic [CNT_W-1:0] cnt, cap, sel_low, sel_len;
  logic             line_s, rise;

  assign cmd_ready = !busy;
  assign start     = cmd_valid && !busy;

  always_comb begin
    unique case (slot_kind_e'(cmd_kind))
      SLOT_RESET: begin sel_low = CNT_W'(RESET_LOW); sel_len = L_RESET; end
      SLOT_WR0:   begin sel_low = CNT_W'(WR0_LOW);   sel_len = L_BIT;   end
      SLOT_WR1:   begin sel_low = CNT_W'(WR1_LOW);   sel_len = L_BIT;   end
      default:    begin sel_low = CNT_W'(RD_LOW);    sel_len = L_BIT;   end
    endcase
  end

  ow_slot_timer #(.CNT_W(CNT_W)) i_timer (
    .clk(clk), .rst(rst), .tick(tick_1us), .start(start),
    .low_len(sel_low), .slot_len(sel_len), .cnt(cnt), .busy(busy),
    .drive_low(drive_low), .end_pulse(end_pulse)
  );

  ow_line_sync #(.STAGES(SYNC_STAGES)) i_sync (
    .clk(clk), .rst(rst), .line_in(line_in), .line_s(line_s), .rise(rise)
  );

  ow_rise_capture #(.CNT_W(CNT_W)) i_cap (
    .clk(clk), .rst(rst), .start(start), .slot_len(sel_len), .busy(busy),
    .drive_low(drive_low), .cnt(cnt), .rise(rise), .cap(cap)
  );

  always_ff @(posedge clk) begin
    if (rst) kind_q <= SLOT_RESET;
    else if (start) kind_q <= slot_kind_e'(cmd_kind);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      presence  <= 1'b0;
      rd_bit    <= 1'b0;
      rd_byte   <= '0;
      rd_valid  <= 1'b0;
      slot_done <= 1'b0;
    end else begin
      slot_done <= end_pulse;
      rd_valid  <= 1'b0;
      if (end_pulse) begin
        if (kind_q == SLOT_RESET)
          presence <= (cap > B_PRES) && (cap != L_RESET);
        if (kind_q == SLOT_READ) begin
          rd_valid <= 1'b1;
          rd_bit   <= (cap < B_READ);
          rd_byte  <= {(cap < B_READ), rd_byte[BYTE_W-1:1]};
        end
      end
    end
  end

  assert_done_single_R8: assert property (@(posedge clk) disable iff (rst)
    slot_done |=> !slot_done);
  assert_rdvalid_with_done_R5: assert property (@(posedge clk) disable iff (rst)
    rd_valid |-> slot_done);
  assert_accept_drops_ready_R2: assert property (@(posedge clk) disable iff (rst)
    (cmd_valid && cmd_ready) |=> !cmd_ready);
  assert_presence_only_reset_R4: assert property (@(posedge clk) disable iff (rst)
    !(end_pulse && kind_q == SLOT_RESET) |=> $stable(presence));
  assert_line_unused_ok_R6: assert property (@(posedge clk) disable iff (rst)
    (drive_low && $past(drive_low) && $past(drive_low, 2) && $past(drive_low, 3)) |-> !line_s);
endmodule

// File: tb/test_ow_slot_engine.sv
module test_ow_slot_engine;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       tick_1us = 1'b0;
  logic       cmd_valid = 1'b0;
  logic [1:0] cmd_kind = 2'd0;
  logic       dev_low = 1'b0;
  logic       line_in;
  logic       cmd_ready, drive_low, presence, rd_bit, rd_valid, slot_done;
  logic [7:0] rd_byte;

  int n_chk  = 0;
  int n_fail = 0;

  assign line_in = ~(drive_low | dev_low);

  ow_slot_engine i_ow_slot_engine (
    .clk(clk), .rst(rst), .tick_1us(tick_1us), .cmd_valid(cmd_valid),
    .cmd_ready(cmd_ready), .cmd_kind(cmd_kind), .line_in(line_in),
    .drive_low(drive_low), .presence(presence), .rd_bit(rd_bit),
    .rd_byte(rd_byte), .rd_valid(rd_valid), .slot_done(slot_done)
  );

  always #2 clk = ~clk;

  initial begin
    int div = 0;
    forever begin
      @(posedge clk);
      tick_1us <= (div == 3);
      div = (div == 3) ? 0 : div + 1;
    end
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // Runs one slot; device pulls the line low while a <= ticks elapsed < b.
  task automatic run_slot(input logic [1:0] kind, input int a, input int b,
                          output int lo, output int len, output int rdv);
    lo = 0; len = 0; rdv = 0;
    @(negedge clk); cmd_kind = kind; cmd_valid = 1'b1;
    @(negedge clk); cmd_valid = 1'b0;
    forever begin
      dev_low = (len >= a) && (len < b);
      if (tick_1us && drive_low) lo++;
      if (tick_1us && !cmd_ready) len++;
      if (rd_valid) rdv++;
      if (slot_done) break;
      @(negedge clk);
    end
    dev_low = 1'b0;
  endtask

  task automatic t_reset_state;
    repeat (5) @(negedge clk);
    chk(drive_low == 0, "R1 drive_low", drive_low, 0);
    chk(cmd_ready == 1, "R1 cmd_ready", cmd_ready, 1);
    chk(presence == 0 && rd_bit == 0 && rd_byte == 0, "R1 results", rd_byte, 0);
    rst = 1'b0;
    @(negedge clk);
    chk(rd_valid == 0 && slot_done == 0, "R1 strobes", slot_done, 0);
    chk(cmd_ready == 1, "R1 ready after reset", cmd_ready, 1);
  endtask

  task automatic t_reset_slots;
    int lo, len, rdv;
    run_slot(2'd0, 530, 650, lo, len, rdv);
    chk(len == 1000, "R2 reset slot length", len, 1000);
    chk(lo == 500, "R3 reset low time", lo, 500);
    chk(presence == 1, "R4 late rise gives presence", presence, 1);
    chk(rdv == 0, "R5 no rd_valid on reset", rdv, 0);
    run_slot(2'd0, 510, 540, lo, len, rdv);
    chk(presence == 0, "R4 rise before barrier", presence, 0);
    run_slot(2'd0, 530, 650, lo, len, rdv);
    run_slot(2'd0, 0, 0, lo, len, rdv);
    chk(presence == 0, "R4 no device", presence, 0);
    run_slot(2'd0, 530, 650, lo, len, rdv);
    run_slot(2'd0, 0, 5000, lo, len, rdv);
    chk(presence == 0, "R6 line stuck low no presence", presence, 0);
  endtask

  task automatic t_write_slots;
    int lo, len, rdv;
    logic p0;
    p0 = presence;
    run_slot(2'd1, 0, 0, lo, len, rdv);
    chk(lo == 60, "R3 write-0 low time", lo, 60);
    chk(len == 100, "R2 write-0 slot length", len, 100);
    run_slot(2'd2, 0, 0, lo, len, rdv);
    chk(lo == 6, "R3 write-1 low time", lo, 6);
    chk(len == 100, "R2 write-1 slot length", len, 100);
    chk(presence == p0, "R4 presence kept over writes", presence, p0);
  endtask

  task automatic t_read_slots;
    int lo, len, rdv;
    run_slot(2'd3, 0, 0, lo, len, rdv);
    chk(lo == 2, "R3 read low time", lo, 2);
    chk(len == 100, "R2 read slot length", len, 100);
    chk(rd_bit == 1, "R5 fast rise reads 1", rd_bit, 1);
    chk(rdv == 1, "R5 one rd_valid", rdv, 1);
    run_slot(2'd3, 0, 15, lo, len, rdv);
    chk(rd_bit == 0, "R5 slow rise reads 0", rd_bit, 0);
    run_slot(2'd3, 0, 8, lo, len, rdv);
    chk(rd_bit == 1, "R5 rise at 8 reads 1", rd_bit, 1);
    run_slot(2'd3, 0, 12, lo, len, rdv);
    chk(rd_bit == 0, "R5 rise at 12 reads 0", rd_bit, 0);
    run_slot(2'd3, 0, 5000, lo, len, rdv);
    chk(rd_bit == 0, "R6 stuck low reads 0", rd_bit, 0);
  endtask

  task automatic t_read_byte;
    int lo, len, rdv;
    logic [7:0] pat = 8'hA5;
    for (int i = 0; i < 8; i++) begin
      run_slot(2'd3, 0, pat[i] ? 0 : 15, lo, len, rdv);
      chk(rd_bit == pat[i], "R7 bit order", rd_bit, pat[i]);
    end
    chk(rd_byte == 8'hA5, "R7 byte lsb first", rd_byte, 8'hA5);
  endtask

  task automatic t_busy_hold;
    int hs = 0, len = 0, lo = 0, dn = 0;
    @(negedge clk); cmd_kind = 2'd2; cmd_valid = 1'b1;
    @(negedge clk); cmd_kind = 2'd1;
    forever begin
      if (tick_1us && drive_low) lo++;
      if (tick_1us && !cmd_ready) len++;
      if (cmd_valid && cmd_ready) break;
      @(negedge clk);
    end
    chk(len == 100, "R9 held command waits full slot", len, 100);
    chk(lo == 6, "R9 running slot keeps its kind", lo, 6);
    @(negedge clk); cmd_valid = 1'b0;
    lo = 0; len = 0;
    forever begin
      if (tick_1us && drive_low) lo++;
      if (tick_1us && !cmd_ready) len++;
      if (slot_done) dn++;
      if (cmd_ready && dn >= 2) break;
      if (cmd_ready && len >= 100) hs++;
      if (hs > 4) break;
      @(negedge clk);
    end
    chk(lo == 60, "R9 queued write-0 timing", lo, 60);
    chk(len == 100, "R9 queued slot length", len, 100);
    chk(dn == 2, "R8 one done per slot", dn, 2);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end

  initial begin
    t_reset_state();
    t_reset_slots();
    t_write_slots();
    t_read_slots();
    t_read_byte();
    t_busy_hold();
    repeat (4) @(negedge clk);
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end
endmodule